// File: doc/BRIEF.md
# Bus Utilization Duration Event Counter

This block is a performance-monitoring counter that watches two buses: an internal bus and a secondary PCI-style bus. On every clock it sorts each bus into one of three kinds of cycle. A data cycle has an owner and moves data. An overhead cycle has an owner but moves no data. An idle cycle has no owner. The block also knows which of four masters holds the secondary bus.

Software picks one of eight duration events with a 3-bit select. While counting is enabled, the counter adds one on every clock on which the selected event is true. A clear command zeroes the count and a sticky wrap flag. Utilization is found by reading a busy count against an idle count, or by reading an ownership count against elapsed time.

Top module: `bus_duty_counter`

## Requirements
- R1: An internal-bus clock with `ib_own`, `ib_mst_rdy` and `ib_tgt_rdy` all high is a data cycle. With select 1 and enable set, the counter adds one on that clock.
- R2: A clock on which a bus is owned but its master-ready or target-ready is low is an overhead cycle. It adds nothing under either the idle or the busy select for that bus (selects 0 and 1 for internal, 2 and 3 for secondary).
- R3: A clock on which a bus has no owner (`ib_own` low, or `sb_own` all zeros) is an idle cycle. Select 0 counts internal idle and select 2 counts secondary idle.
- R4: Select 3 counts secondary data cycles, where any bit of `sb_own` is set and both secondary ready inputs are high. This holds whichever master is the owner.
- R5: Selects 4, 5, 6 and 7 count every clock on which `sb_own` bit 0 (this device), bit 1 (master 0), bit 2 (master 1) or bit 3 (master 2) is set. They count whether or not data moves.
- R6: A new select value is applied from the first clock edge at which it is presented. Changing the select does not clear the counter.
- R7: While `cfg_en` is low and no clear is given, the counter holds its value.
- R8: A `cnt_clr` pulse zeroes the counter and the wrap flag at the next edge. It takes priority over an increment in the same cycle.
- R9: When an increment takes the counter from all ones to zero, `cnt_ovf` is set. It stays set until a clear.
- R10: After reset the counter and `cnt_ovf` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ib_own | input | 1 | Internal bus has a granted owner |
| ib_mst_rdy | input | 1 | Internal-bus master can send |
| ib_tgt_rdy | input | 1 | Internal-bus target can accept |
| sb_own | input | 4 | Secondary-bus owner, one-hot: bit0 this device, bit1..3 masters 0..2 |
| sb_mst_rdy | input | 1 | Secondary-bus master can send |
| sb_tgt_rdy | input | 1 | Secondary-bus target can accept |
| cfg_sel | input | 3 | Event select, 0..7 |
| cfg_en | input | 1 | Count enable |
| cnt_clr | input | 1 | Clear pulse for counter and wrap flag |
| cnt_val | output | CNT_W | Current count |
| cnt_ovf | output | 1 | Sticky wrap flag |

## Verification
Two things can happen in the same cycle. A clear can meet an increment, and the increment can be the very one that would wrap the counter and set the flag. The bench counts the secondary-idle event until the counter sits at all ones. It then gives a clear together with one more idle clock. It expects zero and a low flag, because the clear must beat both the increment and the flag set. A second run lets the wrap go through first and confirms that the flag survives the clocks that follow.

// File: rtl/bus_duty_counter.sv
module bus_duty_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ib_own,
  input  logic             ib_mst_rdy,
  input  logic             ib_tgt_rdy,
  input  logic [3:0]       sb_own,
  input  logic             sb_mst_rdy,
  input  logic             sb_tgt_rdy,
  input  logic [2:0]       cfg_sel,
  input  logic             cfg_en,
  input  logic             cnt_clr,
  output logic [CNT_W-1:0] cnt_val,
  output logic             cnt_ovf
);
  localparam int NUM_EV = 8;

  logic ib_data, ib_idle, sb_busy, sb_data, sb_idle, hit;
  logic [NUM_EV-1:0] ev;

  assign ib_data = ib_own & ib_mst_rdy & ib_tgt_rdy;
  assign ib_idle = ~ib_own;
  assign sb_busy = |sb_own;
  assign sb_data = sb_busy & sb_mst_rdy & sb_tgt_rdy;
  assign sb_idle = ~sb_busy;

  assign ev[0] = ib_idle;
  assign ev[1] = ib_data;
  assign ev[2] = sb_idle;
  assign ev[3] = sb_data;

  for (genvar g = 0; g < 4; g++) begin : g_own
    assign ev[4+g] = sb_own[g];
  end

  assign hit = cfg_en & ev[cfg_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_val <= '0;
      cnt_ovf <= 1'b0;
    end else if (cnt_clr) begin
      cnt_val <= '0;
      cnt_ovf <= 1'b0;
    end else if (hit) begin
      cnt_val <= cnt_val + 1'b1;
      if (&cnt_val) cnt_ovf <= 1'b1;
    end
  end
endmodule

module bus_duty_counter_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ib_own,
  input logic             ib_mst_rdy,
  input logic             ib_tgt_rdy,
  input logic [3:0]       sb_own,
  input logic             sb_mst_rdy,
  input logic             sb_tgt_rdy,
  input logic [2:0]       cfg_sel,
  input logic             cfg_en,
  input logic             cnt_clr,
  input logic [CNT_W-1:0] cnt_val,
  input logic             cnt_ovf
);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (cnt_val == '0) && !cnt_ovf);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && !cfg_en) |=> $stable(cnt_val));

  assert_ib_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && cfg_en && cfg_sel == 3'd1 && ib_own && ib_mst_rdy && ib_tgt_rdy)
    |=> cnt_val == CNT_W'($past(cnt_val) + 1'b1));

  assert_ib_owned_not_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && cfg_sel == 3'd0 && ib_own) |=> $stable(cnt_val));

  assert_sb_overhead_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && cfg_sel == 3'd3 && !(sb_mst_rdy && sb_tgt_rdy)) |=> $stable(cnt_val));

  assert_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && cfg_en && cfg_sel[2] && sb_own[cfg_sel[1:0]])
    |=> cnt_val == CNT_W'($past(cnt_val) + 1'b1));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_ovf && !cnt_clr) |=> cnt_ovf);

  assert_ovf_on_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_ovf) |-> ($past(cnt_val) == {CNT_W{1'b1}}) && (cnt_val == '0));
endmodule

bind bus_duty_counter bus_duty_counter_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_bus_duty_counter.sv
module sim_bus_duty_counter;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ib_own = 0, ib_mst_rdy = 0, ib_tgt_rdy = 0;
  logic [3:0] sb_own = '0;
  logic sb_mst_rdy = 0, sb_tgt_rdy = 0;
  logic [2:0] cfg_sel = '0;
  logic cfg_en = 0, cnt_clr = 0;
  logic [W-1:0] cnt_val;
  logic cnt_ovf;

  bus_duty_counter #(.CNT_W(W)) u0 (.*);

  always #4 clk = ~clk;

  typedef struct { logic [W-1:0] cnt; logic ovf; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  logic [W-1:0] m_cnt = '0;
  logic m_ovf = 0;
  bit done = 0;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic drive(input logic io, im, it, input logic [3:0] so, input logic sm, st,
                       input logic [2:0] sel, input logic en, clr, input string tag);
    logic [7:0] ev;
    @(negedge clk);
    ib_own = io; ib_mst_rdy = im; ib_tgt_rdy = it;
    sb_own = so; sb_mst_rdy = sm; sb_tgt_rdy = st;
    cfg_sel = sel; cfg_en = en; cnt_clr = clr;
    ev[0] = !io;
    ev[1] = io && im && it;
    ev[2] = (so == 4'b0);
    ev[3] = (so != 4'b0) && sm && st;
    ev[7:4] = so;
    if (clr) begin m_cnt = '0; m_ovf = 0; end
    else if (en && ev[sel]) begin
      if (m_cnt == {W{1'b1}}) m_ovf = 1;
      m_cnt = m_cnt + 1'b1;
    end
    q.push_back('{m_cnt, m_ovf, tag});
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (cnt_val !== e.cnt || cnt_ovf !== e.ovf) begin
          fails++;
          $display("FAIL %s: cnt=%0d ovf=%0b expected cnt=%0d ovf=%0b",
                   e.tag, cnt_val, cnt_ovf, e.cnt, e.ovf);
        end
      end
    end
  end

  initial begin : watchdog
    #(8*200000);
    fails++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    report();
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #2; checks++;
    if (cnt_val !== '0 || cnt_ovf !== 1'b0) begin
      fails++;
      $display("FAIL R10: cnt=%0d ovf=%0b expected cnt=0 ovf=0", cnt_val, cnt_ovf);
    end
    @(negedge clk); rst_n = 1;

    repeat (3) drive(0,0,0, 4'b0000,0,0, 3'd0,1,0, "R3 ib idle counts");
    drive(1,0,1, 4'b0000,0,0, 3'd0,1,0, "R2 ib overhead not idle");
    drive(1,1,0, 4'b0000,0,0, 3'd1,1,0, "R2 ib overhead not busy");
    repeat (2) drive(1,1,1, 4'b0000,0,0, 3'd1,1,0, "R1 ib data counts");
    drive(0,1,1, 4'b0000,0,0, 3'd1,1,0, "R1 ib unowned not busy");
    drive(0,0,0, 4'b0000,0,0, 3'd1,1,1, "R8 clear");
    drive(0,0,0, 4'b0001,1,1, 3'd3,1,0, "R4 sb device data");
    drive(0,0,0, 4'b0100,1,1, 3'd3,1,0, "R4 sb master1 data");
    drive(0,0,0, 4'b1000,0,1, 3'd3,1,0, "R2 sb overhead not busy");
    drive(0,0,0, 4'b0000,1,1, 3'd3,1,0, "R4 sb unowned not busy");
    drive(0,0,0, 4'b0010,1,0, 3'd2,1,0, "R2 sb overhead not idle");
    drive(0,0,0, 4'b0000,0,0, 3'd2,1,0, "R3 sb idle counts");
    drive(0,0,0, 4'b0000,0,0, 3'd0,1,1, "R8 clear");
    for (int s = 4; s < 8; s++) begin
      drive(0,0,0, 4'b0001 << (s-4), 0,0, 3'(s),1,0, "R5 owner counts without data");
      drive(0,0,0, 4'b0001 << ((s-3)%4), 1,1, 3'(s),1,0, "R5 other owner ignored");
    end
    repeat (2) drive(0,0,0, 4'b0001,0,0, 3'd4,1,0, "R5 device own");
    drive(0,0,0, 4'b0001,0,0, 3'd5,1,0, "R6 new select applied at once");
    drive(0,0,0, 4'b0010,0,0, 3'd5,1,0, "R6 no auto clear on select change");
    repeat (2) drive(1,1,1, 4'b0010,1,1, 3'd5,0,0, "R7 disabled holds");
    drive(0,0,0, 4'b0000,0,0, 3'd2,1,1, "R8 clear");
    repeat (255) drive(0,0,0, 4'b0000,0,0, 3'd2,1,0, "R9 count to all ones");
    drive(0,0,0, 4'b0000,0,0, 3'd2,1,1, "R8 clear beats wrap");
    repeat (255) drive(0,0,0, 4'b0000,0,0, 3'd2,1,0, "R9 count to all ones");
    drive(0,0,0, 4'b0000,0,0, 3'd2,1,0, "R9 wrap sets flag");
    repeat (3) drive(0,0,0, 4'b0000,0,0, 3'd2,1,0, "R9 flag sticky");
    drive(0,0,0, 4'b0001,0,0, 3'd2,0,0, "R9 flag held while disabled");
    drive(0,0,0, 4'b0000,0,0, 3'd2,1,1, "R8 clear drops flag");
    @(negedge clk); cnt_clr = 0; cfg_en = 0;
    wait (q.size() == 0);
    @(negedge clk);
    report();
  end
endmodule